// File: doc/BRIEF.md
# Dual Reference Clock Quality Monitor

This block qualifies two reference clocks at once against a faster local sampling clock. For each reference it measures the spacing of successive falling edges in sampling ticks. From that spacing it works out which of four nominal rates is present: 8 kHz, 1.544 MHz, 2.048 MHz or 19.44 MHz. It then keeps a per-reference valid flag. An input loses its valid flag when it goes silent, when its rate drifts beyond the tolerance, or, for the three fast rates, when a single period is disturbed by more than half a nominal period. It regains the flag only after a clean run of periods.

Both references are judged all the time, so the standby reference always carries a current status. A select input picks which of the two is reported as the active reference. For the active reference the block also gives its frequency code, its valid flag and a one-cycle strobe on its timing edge. That edge is the rising edge at 19.44 MHz and the falling edge at every other rate. Every nominal period is a parameter in sampling ticks, so a simulation can run with short periods.

Top module: `ref_quality_monitor`

## Requirements
- R1: After reset each reference reports frequency code 0 and valid low, and `sel_edge_o` stays low while no reference toggles.
- R2: The code of a reference changes only after MATCH_N (default 4) consecutive measured periods all lie within the tolerance of the same nominal. The tolerance is TOL_PCT percent, default 3. The codes are: 0 for 8 kHz (PER_8K, default 800 ticks), 1 for 1.544 MHz (PER_1M5, default 266), 2 for 2.048 MHz (PER_2M, default 200), 3 for 19.44 MHz (PER_19M, default 100). While valid is high the code holds.
- R3: Valid rises only after RECOV_N (default 64) consecutive clean periods matching the latched code. This applies both at first acquisition and after any failure.
- R4: While valid, a rate offset of 2% stays valid. A rate offset of 4% is beyond tolerance for OFF_N (default 3) consecutive periods, so valid drops. Valid then stays low for as long as the offset remains.
- R5: For codes 1, 2 and 3, a single period that deviates from nominal by more than half a nominal period drops valid at once. For code 0 no such single-period rule applies, and fewer than OFF_N disturbed periods leave valid high.
- R6: When no falling edge arrives for twice the longest nominal period, the reference is lost and its valid drops.
- R7: The two references are judged independently, and a fault on one leaves the status of the other unchanged.
- R8: With `sel_i` at 0 the selected outputs follow reference 0; with `sel_i` at 1 they follow reference 1.
- R9: `sel_edge_o` pulses for one cycle after each rising edge of the selected reference when its code is 3, and after each falling edge otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 2 | Reference clocks; bit 0 is the primary, bit 1 the secondary |
| sel_i | input | 1 | Active reference select, 0 primary, 1 secondary |
| freq_code_o | output | 4 | Frequency code, reference 0 in [1:0], reference 1 in [3:2] |
| ref_valid_o | output | 2 | Valid flag for each reference |
| sel_valid_o | output | 1 | Valid flag of the selected reference |
| sel_code_o | output | 2 | Frequency code of the selected reference |
| sel_edge_o | output | 1 | One-cycle strobe on the timing edge of the selected reference |

## Verification
The bench checks the recovery count at points well before and after 64 periods. A design that counted too few periods, or kept the run across a failure, would show valid high too early. It puts 2% and 4% offsets on either side of the 3% tolerance, so a design with the tolerance off by one step would trip at 2% or hold on at 4%. It displaces an edge on the 8 kHz reference by more than half a period. A design that applied the single-period rule to every rate would then drop an input that should stay valid. It retunes one reference between nominals and checks the timing-edge strobe against the reference level, which exposes a frozen code or a wrong edge polarity.

// File: rtl/rqm_pkg.sv
package rqm_pkg;
  typedef enum logic [1:0] {
    FREQ_8K  = 2'd0,
    FREQ_1M5 = 2'd1,
    FREQ_2M  = 2'd2,
    FREQ_19M = 2'd3
  } freq_e;
endpackage

// File: rtl/rqm_sync.sv
module rqm_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;

  AST_FALL_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R9
endmodule

// File: rtl/rqm_period.sv
module rqm_period #(
  parameter int unsigned LOS_LIM = 1600,
  localparam int unsigned CW     = $clog2(LOS_LIM + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fall_i,
  output logic [CW-1:0] period_o,
  output logic          stb_o,
  output logic          los_o
);
  logic [CW-1:0] cnt_q;
  logic          prev_q;
  logic          los_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      los_q  <= 1'b0;
    end else begin
      los_q <= 1'b0;
      if (fall_i) begin
        cnt_q  <= CW'(1);
        prev_q <= 1'b1;
      end else if (cnt_q < CW'(LOS_LIM)) begin
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(LOS_LIM - 1)) begin
          los_q  <= 1'b1;
          prev_q <= 1'b0;
        end
      end
    end
  end

  assign period_o = cnt_q;
  assign stb_o    = fall_i & prev_q;
  assign los_o    = los_q;

  AST_PERIOD_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> period_o >= CW'(2)); // R4
endmodule

// File: rtl/rqm_judge.sv
module rqm_judge
  import rqm_pkg::*;
#(
  parameter int unsigned CW      = 11,
  parameter int unsigned PER_8K  = 800,
  parameter int unsigned PER_1M5 = 266,
  parameter int unsigned PER_2M  = 200,
  parameter int unsigned PER_19M = 100,
  parameter int unsigned TOL_PCT = 3,
  parameter int unsigned MATCH_N = 4,
  parameter int unsigned RECOV_N = 64,
  parameter int unsigned OFF_N   = 3,
  localparam int unsigned RW     = $clog2(RECOV_N + 1),
  localparam int unsigned OW     = $clog2(OFF_N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] period_i,
  input  logic          stb_i,
  input  logic          los_i,
  output freq_e         code_o,
  output logic          valid_o
);
  localparam int NOM_A [4] = '{int'(PER_8K), int'(PER_1M5), int'(PER_2M), int'(PER_19M)};

  logic [3:0] match;
  logic [3:0] hitv;

  for (genvar k = 0; k < 4; k++) begin : g_nom
    localparam int NK   = NOM_A[k];
    localparam int TOLK = NK * int'(TOL_PCT) / 100;
    localparam int HLFK = NK / 2;
    int dev;
    always_comb begin
      dev      = (int'(period_i) > NK) ? int'(period_i) - NK : NK - int'(period_i);
      match[k] = (dev <= TOLK);
      hitv[k]  = (dev > HLFK);
    end
  end

  freq_e          code_q, cand_q, cand_c;
  logic           valid_q;
  logic [RW-1:0]  run_q, run_nx;
  logic [OW-1:0]  off_q;
  logic           match_any, hit_cur;

  always_comb begin
    cand_c = FREQ_8K;
    for (int k = 0; k < 4; k++) begin
      if (match[k]) cand_c = freq_e'(2'(k));
    end
  end

  assign match_any = |match;
  assign hit_cur   = (code_q != FREQ_8K) && hitv[code_q];
  assign run_nx    = (run_q != '0 && cand_q == cand_c && run_q < RW'(RECOV_N)) ? run_q + RW'(1) :
                     (run_q != '0 && cand_q == cand_c) ? run_q : RW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= FREQ_8K;
      cand_q  <= FREQ_8K;
      valid_q <= 1'b0;
      run_q   <= '0;
      off_q   <= '0;
    end else if (los_i) begin
      valid_q <= 1'b0;
      run_q   <= '0;
      off_q   <= '0;
    end else if (stb_i) begin
      if (valid_q) begin
        if (hit_cur) begin
          valid_q <= 1'b0;
          run_q   <= '0;
          off_q   <= '0;
        end else if (!match[code_q]) begin
          if (off_q == OW'(OFF_N - 1)) begin
            valid_q <= 1'b0;
            run_q   <= '0;
            off_q   <= '0;
          end else begin
            off_q <= off_q + OW'(1);
          end
        end else begin
          off_q <= '0;
        end
      end else if (match_any) begin
        cand_q <= cand_c;
        run_q  <= run_nx;
        if (run_nx == RW'(MATCH_N)) code_q <= cand_c;
        if (run_nx == RW'(RECOV_N)) begin
          valid_q <= 1'b1;
          off_q   <= '0;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;

  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && $past(valid_q) |-> $stable(code_q)); // R2
  AST_RISE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(stb_i) && $past(run_q) == RW'(RECOV_N - 1)); // R3
  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(RECOV_N)); // R3
  AST_LOS_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_i |=> !valid_q); // R6
endmodule

// File: rtl/ref_quality_monitor.sv
module ref_quality_monitor
  import rqm_pkg::*;
#(
  parameter int unsigned PER_8K  = 800,
  parameter int unsigned PER_1M5 = 266,
  parameter int unsigned PER_2M  = 200,
  parameter int unsigned PER_19M = 100,
  parameter int unsigned TOL_PCT = 3,
  parameter int unsigned MATCH_N = 4,
  parameter int unsigned RECOV_N = 64,
  parameter int unsigned OFF_N   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ref_i,
  input  logic       sel_i,
  output logic [3:0] freq_code_o,
  output logic [1:0] ref_valid_o,
  output logic       sel_valid_o,
  output logic [1:0] sel_code_o,
  output logic       sel_edge_o
);
  localparam int unsigned MAX_A = (PER_8K > PER_1M5) ? PER_8K : PER_1M5;
  localparam int unsigned MAX_B = (PER_2M > PER_19M) ? PER_2M : PER_19M;
  localparam int unsigned MAX_P = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned LOS_LIM = 2 * MAX_P;
  localparam int unsigned CW = $clog2(LOS_LIM + 1);

  freq_e      code_w [2];
  logic [1:0] valid_w, rise_w, fall_w, edge_w;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [CW-1:0] period;
    logic          stb, los;

    rqm_sync i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (ref_i[ch]),
      .rise_o(rise_w[ch]),
      .fall_o(fall_w[ch])
    );

    rqm_period #(.LOS_LIM(LOS_LIM)) i_period (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fall_i  (fall_w[ch]),
      .period_o(period),
      .stb_o   (stb),
      .los_o   (los)
    );

    rqm_judge #(
      .CW(CW), .PER_8K(PER_8K), .PER_1M5(PER_1M5), .PER_2M(PER_2M), .PER_19M(PER_19M),
      .TOL_PCT(TOL_PCT), .MATCH_N(MATCH_N), .RECOV_N(RECOV_N), .OFF_N(OFF_N)
    ) i_judge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .period_i(period),
      .stb_i   (stb),
      .los_i   (los),
      .code_o  (code_w[ch]),
      .valid_o (valid_w[ch])
    );

    assign edge_w[ch] = (code_w[ch] == FREQ_19M) ? rise_w[ch] : fall_w[ch];
  end

  assign freq_code_o = {code_w[1], code_w[0]};
  assign ref_valid_o = valid_w;
  assign sel_valid_o = sel_i ? valid_w[1] : valid_w[0];
  assign sel_code_o  = sel_i ? code_w[1] : code_w[0];
  assign sel_edge_o  = sel_i ? edge_w[1] : edge_w[0];
endmodule

// File: tb/test_ref_quality_monitor.sv
module test_ref_quality_monitor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_r [2];
  logic       sel = 1'b0;
  logic [3:0] freq_code;
  logic [1:0] ref_valid;
  logic       sel_valid, sel_edge;
  logic [1:0] sel_code;

  int hi [2], lo [2], sh [2];
  bit en [2];
  int n_chk = 0, n_fail = 0;
  bit mon_on = 0;
  int n_edge = 0, n_bad_lvl = 0;
  bit exp_lvl = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ref_quality_monitor i_ref_quality_monitor (
    .clk_i(clk), .rst_ni(rst_n), .ref_i({ref_r[1], ref_r[0]}), .sel_i(sel),
    .freq_code_o(freq_code), .ref_valid_o(ref_valid), .sel_valid_o(sel_valid),
    .sel_code_o(sel_code), .sel_edge_o(sel_edge)
  );

  task automatic run_gen(input int ch);
    forever begin
      if (!en[ch]) @(negedge clk);
      else begin
        int h, l;
        h = hi[ch] + sh[ch];
        l = lo[ch] - sh[ch];
        sh[ch] = 0;
        ref_r[ch] = 1'b1;
        repeat (h) @(negedge clk);
        ref_r[ch] = 1'b0;
        repeat (l) @(negedge clk);
      end
    end
  endtask

  initial begin ref_r[0] = 1'b0; run_gen(0); end
  initial begin ref_r[1] = 1'b0; run_gen(1); end

  initial forever begin
    @(negedge clk);
    #1;
    if (mon_on && sel_edge) begin
      n_edge++;
      if (ref_r[sel] !== exp_lvl) n_bad_lvl++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_per(input int ch, input int n);
    repeat (n * (hi[ch] + lo[ch])) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    #1;
    chk("R1 codes", freq_code, 4'h0);
    chk("R1 valid", ref_valid, 2'b00);
    chk("R1 edge", sel_edge, 1'b0);
  endtask

  task automatic t_acquire;
    hi[0] = 20;  lo[0] = 80;  en[0] = 1;
    hi[1] = 100; lo[1] = 700; en[1] = 1;
    wait_per(0, 30);
    chk("R2 ch0 code 19M", freq_code[1:0], 2'd3);
    chk("R3 ch0 not yet valid", ref_valid[0], 1'b0);
    wait_per(0, 40);
    chk("R3 ch0 valid", ref_valid[0], 1'b1);
    wait_per(1, 37);
    chk("R3 ch1 not yet valid", ref_valid[1], 1'b0);
    wait_per(1, 25);
    chk("R3 ch1 valid", ref_valid[1], 1'b1);
    chk("R2 ch1 code 8k", freq_code[3:2], 2'd0);
  endtask

  task automatic t_select;
    sel = 1'b0;
    #1;
    chk("R8 sel0 code", sel_code, 2'd3);
    chk("R8 sel0 valid", sel_valid, 1'b1);
    n_edge = 0; n_bad_lvl = 0; exp_lvl = 1'b1; mon_on = 1;
    wait_per(0, 5);
    mon_on = 0;
    chk("R9 rising edges seen", 32'(n_edge > 3), 1);
    chk("R9 rising polarity", n_bad_lvl, 0);
    sel = 1'b1;
    #1;
    chk("R8 sel1 code", sel_code, 2'd0);
    chk("R8 sel1 valid", sel_valid, 1'b1);
    n_edge = 0; n_bad_lvl = 0; exp_lvl = 1'b0; mon_on = 1;
    wait_per(1, 3);
    mon_on = 0;
    chk("R9 falling edges seen", 32'(n_edge > 1), 1);
    chk("R9 falling polarity", n_bad_lvl, 0);
    sel = 1'b0;
  endtask

  task automatic t_offset;
    lo[0] = 82;
    wait_per(0, 20);
    chk("R4 +2% stays valid", ref_valid[0], 1'b1);
    lo[0] = 78;
    wait_per(0, 20);
    chk("R4 -2% stays valid", ref_valid[0], 1'b1);
    lo[0] = 84;
    wait_per(0, 10);
    chk("R4 +4% drops valid", ref_valid[0], 1'b0);
    wait_per(0, 80);
    chk("R4 +4% stays invalid", ref_valid[0], 1'b0);
    chk("R2 code kept", freq_code[1:0], 2'd3);
    lo[0] = 80;
    wait_per(0, 70);
    chk("R3 recovered after offset", ref_valid[0], 1'b1);
  endtask

  task automatic t_phase_hit;
    sh[0] = 60;
    wait_per(0, 5);
    chk("R5 hit drops valid", ref_valid[0], 1'b0);
    chk("R7 ch1 untouched by ch0 hit", ref_valid[1], 1'b1);
    wait_per(0, 40);
    chk("R3 no early recovery", ref_valid[0], 1'b0);
    wait_per(0, 30);
    chk("R3 recovered after hit", ref_valid[0], 1'b1);
    sh[1] = 500;
    wait_per(1, 4);
    chk("R5 8k displaced edge stays valid", ref_valid[1], 1'b1);
    chk("R7 ch0 untouched", ref_valid[0], 1'b1);
  endtask

  task automatic t_dropout;
    en[0] = 0;
    repeat (2000) @(negedge clk);
    #1;
    chk("R6 loss drops valid", ref_valid[0], 1'b0);
    chk("R7 ch1 valid during ch0 loss", ref_valid[1], 1'b1);
    en[0] = 1;
    wait_per(0, 70);
    chk("R3 recovered after loss", ref_valid[0], 1'b1);
  endtask

  task automatic t_retune;
    hi[0] = 40; lo[0] = 160;
    wait_per(0, 10);
    chk("R5 retune drops valid", ref_valid[0], 1'b0);
    chk("R2 code 2M", freq_code[1:0], 2'd2);
    wait_per(0, 60);
    chk("R3 valid at 2M", ref_valid[0], 1'b1);
    hi[0] = 50; lo[0] = 216;
    wait_per(0, 70);
    chk("R2 code 1M5", freq_code[1:0], 2'd1);
    chk("R8 sel0 follows retune", sel_code, 2'd1);
    chk("R3 valid at 1M5", ref_valid[0], 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    hi = '{20, 100}; lo = '{80, 700}; sh = '{0, 0}; en = '{0, 0};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_acquire();
    t_select();
    t_offset();
    t_phase_hit();
    t_dropout();
    t_retune();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule